// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Selective Invalidation

This block is a small fully associative cache of 4 KB page translations for an I/O address translation unit. Each cached entry holds a 7-bit address-space identifier, the 20-bit virtual page number (virtual address bits [31:12]), a physical frame number and three permission bits: readable, writable and nonsecure. A client presents an address-space identifier and a 32-bit virtual address on the lookup port and gets hit, frame number and permissions back in the same cycle. A page walker installs new translations through the refill port. Victims are chosen in strict rotation.

Software keeps the cache coherent with the page tables by writing one packed 32-bit invalidation command. The command picks the address scope from its two low bits. It can qualify the invalidation with an address-space identifier, so it can drop every entry, one address space, one 4 MB section or one 16 KB group of pages.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: When lkp_valid_i is high, a lookup hits if a valid entry has the same identifier and its page number equals lkp_va_i[31:12]. On a hit lkp_pfn_o and {lkp_rd_o, lkp_wr_o, lkp_ns_o} carry that entry's contents in the same cycle, and the lowest-numbered matching entry wins. On a miss, or with lkp_valid_i low, all outputs are zero.
- R3: Refills write slots in rotation starting at slot 0, one slot per refill, and wrap after NUM_ENTRIES-1. The (NUM_ENTRIES+1)-th refill evicts the first entry.
- R4: A command with flush_cmd_i[1:0]=0 and flush_cmd_i[31]=0 invalidates every entry.
- R5: flush_cmd_i[31]=1 limits any invalidation to entries whose identifier equals flush_cmd_i[30:24]. With type 0 this removes exactly that address space.
- R6: Type 2 (section) invalidates entries whose page number bits [19:10] (address bits [31:22]) equal flush_cmd_i[19:10].
- R7: Type 3 (group) invalidates entries whose page number bits [19:2] (address bits [31:14]) equal flush_cmd_i[19:2].
- R8: With flush_cmd_i[31]=0, a section or group command invalidates matching entries in every address space.
- R9: Type 1 is reserved and leaves every entry untouched.
- R10: A lookup in the same cycle as an invalidation sees the contents after that invalidation.
- R11: A refill in the same cycle as an invalidation is installed and survives it.
- R12: flush_cmd_i is ignored while flush_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_asid_i | input | 7 | Lookup address-space identifier |
| lkp_va_i | input | 32 | Lookup virtual address |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_pfn_o | output | PFN_W | Physical frame number of the hit |
| lkp_rd_o | output | 1 | Readable permission of the hit |
| lkp_wr_o | output | 1 | Writable permission of the hit |
| lkp_ns_o | output | 1 | Nonsecure attribute of the hit |
| fill_valid_i | input | 1 | Refill request |
| fill_asid_i | input | 7 | Refill identifier |
| fill_vpn_i | input | 20 | Refill virtual page number |
| fill_pfn_i | input | PFN_W | Refill frame number |
| fill_rd_i | input | 1 | Refill readable bit |
| fill_wr_i | input | 1 | Refill writable bit |
| fill_ns_i | input | 1 | Refill nonsecure bit |
| flush_valid_i | input | 1 | Invalidation command strobe |
| flush_cmd_i | input | 32 | Packed invalidation command |

## Verification
The bench builds the block with its defaults: 8 entries and a 20-bit frame number. Eight entries let a few refills wrap the rotation pointer and evict live translations. The bench draws identifiers from four values and page numbers from a narrow pool that spans four sections and four groups per section. This makes same-address, cross-space and same-section-different-group collisions frequent, so each invalidation scope both hits and spares entries, including in cycles that also carry a lookup and a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;
  localparam int VA_W   = 32;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_RSVD    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } flush_kind_e;

  typedef struct packed {
    logic              active;
    logic              asid_en;
    logic [ASID_W-1:0] asid;
    flush_kind_e       kind;
    logic [17:0]       addr;   // command bits [19:2]
  } flush_req_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic              rd;
    logic              wr;
    logic              ns;
  } tlb_tag_t;
endpackage

// File: rtl/tlb_flush_decode.sv
module tlb_flush_decode
  import tlb_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] cmd_i,
  output flush_req_t  req_o
);
  flush_kind_e kind;
  logic        unused_cmd;

  assign kind       = flush_kind_e'(cmd_i[1:0]);
  assign unused_cmd = ^cmd_i[23:20];

  always_comb begin
    req_o.active  = valid_i && (kind != FL_RSVD);
    req_o.asid_en = cmd_i[31];
    req_o.asid    = cmd_i[30:24];
    req_o.kind    = kind;
    req_o.addr    = cmd_i[19:2];
  end
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
(
  input  logic              valid_i,
  input  tlb_tag_t          tag_i,
  input  flush_req_t        req_i,
  input  logic              lkp_valid_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  output logic              kill_o,
  output logic              hit_o
);
  logic addr_ok, asid_ok;

  always_comb begin
    unique case (req_i.kind)
      FL_ALL:     addr_ok = 1'b1;
      FL_SECTION: addr_ok = (tag_i.vpn[19:10] == req_i.addr[17:8]);
      FL_GROUP:   addr_ok = (tag_i.vpn[19:2] == req_i.addr);
      default:    addr_ok = 1'b0;
    endcase
  end

  assign asid_ok = !req_i.asid_en || (tag_i.asid == req_i.asid);
  assign kill_o  = valid_i && req_i.active && addr_ok && asid_ok;
  // lookup observes post-invalidation state
  assign hit_o   = lkp_valid_i && valid_i && !kill_o &&
                   (tag_i.asid == lkp_asid_i) && (tag_i.vpn == lkp_vpn_i);
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  // R3
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1));
  // R3
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/tlb_asid_cache.sv
module tlb_asid_cache
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PFN_W       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [6:0]        lkp_asid_i,
  input  logic [31:0]       lkp_va_i,
  output logic              lkp_hit_o,
  output logic [PFN_W-1:0]  lkp_pfn_o,
  output logic              lkp_rd_o,
  output logic              lkp_wr_o,
  output logic              lkp_ns_o,
  input  logic              fill_valid_i,
  input  logic [6:0]        fill_asid_i,
  input  logic [19:0]       fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_ns_i,
  input  logic              flush_valid_i,
  input  logic [31:0]       flush_cmd_i
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] valid_q, kill, hit;
  tlb_tag_t               tag_q [NUM_ENTRIES];
  logic [PFN_W-1:0]       pfn_q [NUM_ENTRIES];
  logic [IDX_W-1:0]       fill_ptr;
  flush_req_t             freq;
  logic [VPN_W-1:0]       lkp_vpn;
  logic                   unused_off;

  assign lkp_vpn    = lkp_va_i[31:12];
  assign unused_off = ^lkp_va_i[11:0];

  tlb_flush_decode i_dec (
    .valid_i (flush_valid_i),
    .cmd_i   (flush_cmd_i),
    .req_o   (freq)
  );

  tlb_rr_ptr #(.NUM_ENTRIES(NUM_ENTRIES)) i_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_valid_i),
    .ptr_o  (fill_ptr)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    tlb_entry_match i_match (
      .valid_i     (valid_q[e]),
      .tag_i       (tag_q[e]),
      .req_i       (freq),
      .lkp_valid_i (lkp_valid_i),
      .lkp_asid_i  (lkp_asid_i),
      .lkp_vpn_i   (lkp_vpn),
      .kill_o      (kill[e]),
      .hit_o       (hit[e])
    );
  end

  // refill wins over a same-cycle invalidation of its slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tag_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (fill_valid_i && (fill_ptr == IDX_W'(i))) begin
          valid_q[i]    <= 1'b1;
          tag_q[i].asid <= fill_asid_i;
          tag_q[i].vpn  <= fill_vpn_i;
          tag_q[i].rd   <= fill_rd_i;
          tag_q[i].wr   <= fill_wr_i;
          tag_q[i].ns   <= fill_ns_i;
          pfn_q[i]      <= fill_pfn_i;
        end else if (kill[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  // lowest index wins
  always_comb begin
    lkp_hit_o = 1'b0;
    lkp_pfn_o = '0;
    lkp_rd_o  = 1'b0;
    lkp_wr_o  = 1'b0;
    lkp_ns_o  = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        lkp_hit_o = 1'b1;
        lkp_pfn_o = pfn_q[i];
        lkp_rd_o  = tag_q[i].rd;
        lkp_wr_o  = tag_q[i].wr;
        lkp_ns_o  = tag_q[i].ns;
      end
    end
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_valid_i);
  // R3
  fill_sets_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> valid_q[$past(fill_ptr)]);
  // R4
  flush_all_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_valid_i && flush_cmd_i[1:0] == 2'd0 && !flush_cmd_i[31] && !fill_valid_i)
      |=> valid_q == '0);
  // R9
  rsvd_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_valid_i && flush_cmd_i[1:0] == 2'd1 && !fill_valid_i) |=> $stable(valid_q));
  // R12
  no_strobe_no_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_valid_i && !fill_valid_i) |=> $stable(valid_q));
  // R11
  fill_survives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && flush_valid_i) |=> valid_q[$past(fill_ptr)]);
endmodule

// File: tb/test_tlb_asid_cache.sv
module test_tlb_asid_cache;
  localparam int N = 8;
  localparam int PFN_W = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lkp_valid = 0, fill_valid = 0, flush_valid = 0;
  logic [6:0] lkp_asid = 0, fill_asid = 0;
  logic [31:0] lkp_va = 0, flush_cmd = 0;
  logic [19:0] fill_vpn = 0;
  logic [PFN_W-1:0] fill_pfn = 0, lkp_pfn;
  logic fill_rd = 0, fill_wr = 0, fill_ns = 0;
  logic lkp_hit, lkp_rd, lkp_wr, lkp_ns;

  int n_chk = 0, n_fail = 0;

  bit         m_valid [N];
  logic [6:0] m_asid  [N];
  logic [19:0] m_vpn  [N];
  logic [PFN_W-1:0] m_pfn [N];
  logic [2:0] m_attr  [N];
  int         m_ptr = 0;

  always #4 clk = ~clk;

  tlb_asid_cache #(.NUM_ENTRIES(N), .PFN_W(PFN_W)) i_tlb_asid_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid), .lkp_asid_i(lkp_asid), .lkp_va_i(lkp_va),
    .lkp_hit_o(lkp_hit), .lkp_pfn_o(lkp_pfn),
    .lkp_rd_o(lkp_rd), .lkp_wr_o(lkp_wr), .lkp_ns_o(lkp_ns),
    .fill_valid_i(fill_valid), .fill_asid_i(fill_asid), .fill_vpn_i(fill_vpn),
    .fill_pfn_i(fill_pfn), .fill_rd_i(fill_rd), .fill_wr_i(fill_wr), .fill_ns_i(fill_ns),
    .flush_valid_i(flush_valid), .flush_cmd_i(flush_cmd)
  );

  function automatic bit m_kill(int i);
    bit a_ok, s_ok;
    if (!flush_valid || !m_valid[i]) return 0;
    s_ok = !flush_cmd[31] || (m_asid[i] == flush_cmd[30:24]);
    case (flush_cmd[1:0])
      2'd0: a_ok = 1;
      2'd2: a_ok = (m_vpn[i][19:10] == flush_cmd[19:10]);
      2'd3: a_ok = (m_vpn[i][19:2] == flush_cmd[19:2]);
      default: a_ok = 0;
    endcase
    return a_ok && s_ok;
  endfunction

  function automatic logic [31:0] mk_cmd(bit asid_en, logic [6:0] asid,
                                         logic [1:0] kind, logic [31:0] va);
    logic [31:0] c;
    c = {asid_en, asid, 24'h0};
    case (kind)
      2'd2: c[19:10] = va[31:22];
      2'd3: c[19:2]  = va[31:14];
      2'd1: c[19:2]  = va[31:14];
      default: ;
    endcase
    c[1:0] = kind;
    return c;
  endfunction

  function automatic logic [19:0] rnd_vpn();
    return {8'h00, 2'($urandom), 6'h00, 2'($urandom), 2'($urandom)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already set after a falling edge; check, then commit the model
  task automatic step(string tag);
    logic [31:0] exp;
    #1;
    exp = '0;
    if (lkp_valid) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_valid[i] && !m_kill(i) && m_asid[i] == lkp_asid && m_vpn[i] == lkp_va[31:12])
          exp = {1'b1, 8'h0, m_attr[i], m_pfn[i]};
    end
    check(tag, {lkp_hit, 8'h0, lkp_rd, lkp_wr, lkp_ns, lkp_pfn}, exp);
    @(posedge clk);
    for (int i = 0; i < N; i++) if (m_kill(i)) m_valid[i] = 0;
    if (fill_valid) begin
      m_valid[m_ptr] = 1; m_asid[m_ptr] = fill_asid; m_vpn[m_ptr] = fill_vpn;
      m_pfn[m_ptr] = fill_pfn; m_attr[m_ptr] = {fill_rd, fill_wr, fill_ns};
      m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    lkp_valid = 0; fill_valid = 0; flush_valid = 0;
  endtask

  task automatic set_fill(logic [6:0] a, logic [19:0] v, logic [PFN_W-1:0] p, logic [2:0] at);
    fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p;
    {fill_rd, fill_wr, fill_ns} = at;
  endtask

  task automatic set_lkp(logic [6:0] a, logic [19:0] v);
    lkp_valid = 1; lkp_asid = a; lkp_va = {v, 12'($urandom)};
  endtask

  task automatic set_flush(bit ae, logic [6:0] a, logic [1:0] k, logic [19:0] v);
    flush_valid = 1; flush_cmd = mk_cmd(ae, a, k, {v, 12'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1: empty after reset
    set_lkp(7'd0, 20'h0); step("R1");
    set_lkp(7'd5, 20'h00401); step("R1");
    // R2: fill then hit / wrong-space miss
    set_fill(7'd1, 20'h00401, 20'hAAAAA, 3'b101); step("R3");
    set_lkp(7'd1, 20'h00401); step("R2");
    set_lkp(7'd2, 20'h00401); step("R2");
    lkp_asid = 7'd1; lkp_va = 32'h00401000; step("R2");
    // R3: eight more refills evict the first
    for (int i = 1; i <= N; i++) begin
      set_fill(7'(i % 4), 20'h00800 + 20'(i * 4), 20'(i * 17), 3'(i)); step("R3");
    end
    set_lkp(7'd1, 20'h00401); step("R3");
    set_lkp(7'(N % 4), 20'h00800 + 20'(N * 4)); step("R3");
    // R2: duplicate translations, lowest slot wins
    set_fill(7'd3, 20'h00C00, 20'h11111, 3'b100); step("R3");
    set_fill(7'd3, 20'h00C00, 20'h22222, 3'b010); step("R3");
    set_lkp(7'd3, 20'h00C00); step("R2");
    // R5 + R10: space flush with same-cycle lookup
    set_flush(1, 7'd3, 2'd0, 20'h0); set_lkp(7'd3, 20'h00C00); step("R10");
    set_lkp(7'd1, 20'h00804); step("R5");
    set_lkp(7'd2, 20'h00808); step("R5");
    // refill a known set for address-scoped flushes
    set_fill(7'd1, 20'h00C04, 20'h00001, 3'b111); step("R3");
    set_fill(7'd1, 20'h00C08, 20'h00002, 3'b111); step("R3");
    set_fill(7'd2, 20'h00C04, 20'h00003, 3'b111); step("R3");
    set_fill(7'd1, 20'h00404, 20'h00004, 3'b111); step("R3");
    // R7: group flush in space 1
    set_flush(1, 7'd1, 2'd3, 20'h00C05); set_lkp(7'd1, 20'h00C04); step("R7");
    set_lkp(7'd1, 20'h00C08); step("R7");
    set_lkp(7'd2, 20'h00C04); step("R7");
    // R9: reserved type
    set_flush(0, 7'd0, 2'd1, 20'h00C08); step("R9");
    set_lkp(7'd1, 20'h00C08); step("R9");
    // R12: strobe low
    flush_cmd = 32'h0; step("R12");
    set_lkp(7'd2, 20'h00C04); step("R12");
    // R6: section flush in space 1
    set_flush(1, 7'd1, 2'd2, 20'h00C3F); step("R6");
    set_lkp(7'd1, 20'h00C08); step("R6");
    set_lkp(7'd2, 20'h00C04); step("R6");
    set_lkp(7'd1, 20'h00404); step("R6");
    // R8: section flush for all spaces
    set_flush(0, 7'd0, 2'd2, 20'h00C00); set_lkp(7'd2, 20'h00C04); step("R8");
    set_lkp(7'd1, 20'h00404); step("R8");
    // R11: refill with same-cycle full flush
    set_fill(7'd6, 20'h00123, 20'h0BEEF, 3'b011); set_flush(0, 7'd0, 2'd0, 20'h0); step("R11");
    set_lkp(7'd6, 20'h00123); step("R11");
    // R4: flush everything
    set_flush(0, 7'd0, 2'd0, 20'h0); step("R4");
    set_lkp(7'd6, 20'h00123); step("R4");
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 2) == 0)
        set_fill(7'($urandom_range(0, 3)), rnd_vpn(), PFN_W'($urandom), 3'($urandom));
      if ($urandom_range(0, 6) == 0)
        set_flush(1'($urandom), 7'($urandom_range(0, 3)), 2'($urandom), rnd_vpn());
      else if ($urandom_range(0, 9) == 0) flush_cmd = $urandom;
      if ($urandom_range(0, 3) != 0) set_lkp(7'($urandom_range(0, 3)), rnd_vpn());
      step("R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule